// File: doc/BRIEF.md
# Reference Divider with Phase-Frequency Detector and Lock Monitor

This block sits in the digital part of a fractional-N frequency synthesizer. It runs on the reference input clock. A programmable counter divides that clock by a ratio of up to 12 bits. A power-of-two stage then divides the result again by 1, 2, 4 or 8. The reference divider marks each reference comparison event with a one-cycle low pulse.

A two-flip-flop phase-frequency detector compares those events with the falling edges of the main-divider output. It drives an up request, which means the VCO frequency should rise, and a down request, which means it should fall. Once both requests are set, they clear together on the next reference clock edge. The resulting one-cycle minimum pulse on both outputs removes the dead zone near zero phase error.

The block also opens a three-cycle window around each reference event to time the fractional compensation current. It watches the detector pulses to decide lock. It drives one shared status pin that can show the lock flag, the reference divider output or the main divider input. The charge-pump current setting passes through unchanged.

Top module: `refpfd_top`

## Requirements
- R1: The reference period is P = max(ratio_i, 4) * 2^post_sel_i clock cycles. Ratio values below 4 act as 4. After en_i rises, ref_div_o goes low for exactly one cycle at cycle index P-1, with the enable cycle counted as index 0, and again every P cycles after that.
- R2: post_sel_i encodes the extra division: 2'b00 divides by 1, 2'b01 by 2, 2'b10 by 4 and 2'b11 by 8.
- R3: up_o goes high in the cycle after a reference event. dn_o goes high in the cycle after the cycle in which main_div_i is first sampled low. In the first cycle where both are high, both clear at the next edge. With zero phase error, each of them is therefore high for exactly one cycle.
- R4: comp_win_o is high in the cycle before a reference event, in the event cycle and in the cycle after it. It is low in the cycle before that three-cycle window and in the cycle after it.
- R5: A comparison is good when it ends with up_o and dn_o both high and neither has been high for two cycles in a row. lock_o rises in the cycle after the fourth consecutive good comparison.
- R6: When up_o or dn_o is still high in its second consecutive cycle, lock_o is low from the next cycle on and the run of good comparisons restarts.
- R7: While en_i is low, the following hold: the dividers and the detector are held cleared, up_o and dn_o are low, ref_div_o is high, comp_win_o is low and lock_o is high.
- R8: test_sel_i selects status_o as follows: 2'b00 and 2'b10 give lock_o, 2'b01 gives ref_div_o and 2'b11 gives main_div_i.
- R9: level_o always equals level_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Synthesizer enable; low holds the block cleared |
| ratio_i | input | 12 | Programmable reference ratio |
| post_sel_i | input | 2 | Power-of-two post-division select |
| test_sel_i | input | 2 | Status pin source select |
| main_div_i | input | 1 | Main divider output, synchronous to clk; falling edge is the event |
| level_i | input | 8 | Charge-pump current setting |
| ref_div_o | output | 1 | Reference divider output, active-low one-cycle pulse |
| up_o | output | 1 | Detector up request (source current) |
| dn_o | output | 1 | Detector down request (sink current) |
| comp_win_o | output | 1 | Fractional compensation timing window |
| lock_o | output | 1 | Lock indication |
| status_o | output | 1 | Shared status pin |
| level_o | output | 8 | Charge-pump current setting, passed through |

## Verification
The properties take for granted that ratio_i and post_sel_i change only while en_i is low. A mid-count change could end a period with no look-ahead cycle. They also assume that main_div_i is synchronous to clk and that a main-divider falling edge never arrives in the cycle in which the detector is clearing. The stimulus reprograms the divider only between disable and enable. It drops main_div_i for single cycles that sit at most two cycles from a reference event, so detector clears and new events never collide.

// File: rtl/refpfd_pkg.sv
package refpfd_pkg;

  localparam int RATIO_W   = 12;
  localparam int SEL_W     = 2;
  localparam int MIN_RATIO = 4;

  typedef enum logic [1:0] {
    ST_LOCK     = 2'b00,
    ST_REF      = 2'b01,
    ST_LOCK_ALT = 2'b10,
    ST_MAIN     = 2'b11
  } status_sel_t;

  // Ratios below the legal floor are raised to the floor.
  function automatic logic [RATIO_W-1:0] eff_ratio(input logic [RATIO_W-1:0] r);
    return (r < RATIO_W'(MIN_RATIO)) ? RATIO_W'(MIN_RATIO) : r;
  endfunction

  // Low bits of the post counter that must all be one for an event.
  function automatic logic [(1<<SEL_W)-2:0] post_mask(input logic [SEL_W-1:0] sel);
    logic [(1<<SEL_W)-2:0] m;
    for (int i = 0; i < (1<<SEL_W)-1; i++) m[i] = (i < int'(sel));
    return m;
  endfunction

endpackage

// File: rtl/refpfd_refdiv.sv
module refpfd_refdiv
  import refpfd_pkg::*;
#(
  parameter int RW = RATIO_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [RW-1:0] ratio,
  input  logic [SW-1:0] post_sel,
  output logic          evt,
  output logic          pre,
  output logic          post
);
  localparam int PW = (1 << SW) - 1;

  logic [RW-1:0] pcnt;
  logic [RW-1:0] last_val;
  logic [PW-1:0] post_cnt;
  logic [PW-1:0] mask;
  logic          tick;
  logic          full;

  assign last_val = eff_ratio(ratio) - RW'(1);
  assign mask     = post_mask(post_sel);
  assign tick     = (pcnt >= last_val);
  assign full     = ((post_cnt & mask) == mask);
  assign evt      = tick & full;
  assign pre      = (pcnt == last_val - RW'(1)) & full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt     <= '0;
      post_cnt <= '0;
      post     <= 1'b0;
    end else if (!en) begin
      pcnt     <= '0;
      post_cnt <= '0;
      post     <= 1'b0;
    end else begin
      post <= evt;
      if (tick) begin
        pcnt     <= '0;
        post_cnt <= post_cnt + PW'(1);
      end else begin
        pcnt <= pcnt + RW'(1);
      end
    end
  end

  // R2: the post counter advances by one on every programmable-divider tick
  p_post_step_r2: assert property (@(posedge clk) disable iff (!rst_n || !en)
    tick |=> (post_cnt == $past(post_cnt) + PW'(1)));

  // R4: every reference event is announced one cycle ahead
  p_pre_leads_evt_r4: assert property (@(posedge clk) disable iff (!rst_n || !en)
    evt |-> $past(pre));

endmodule

// File: rtl/refpfd_detector.sv
module refpfd_detector (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ref_evt,
  input  logic main_i,
  output logic up_q,
  output logic dn_q
);
  logic main_prev;
  logic main_fall;
  logic both;

  assign main_fall = main_prev & ~main_i;
  assign both      = up_q & dn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q      <= 1'b0;
      dn_q      <= 1'b0;
      main_prev <= 1'b0;
    end else if (!en) begin
      up_q      <= 1'b0;
      dn_q      <= 1'b0;
      main_prev <= 1'b0;
    end else begin
      main_prev <= main_i;
      if (both) begin
        up_q <= 1'b0;
        dn_q <= 1'b0;
      end else begin
        up_q <= up_q | ref_evt;
        dn_q <= dn_q | main_fall;
      end
    end
  end

  // R3: the overlap of both requests never lasts past one cycle
  p_overlap_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    both |=> !(up_q && dn_q));

  // R3: a down request starts only after a sampled main falling edge
  p_dn_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n || !en)
    $rose(dn_q) |-> $past(main_fall));

endmodule

// File: rtl/refpfd_lockmon.sv
module refpfd_lockmon #(
  parameter int LOCK_COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic up_q,
  input  logic dn_q,
  output logic locked
);
  localparam int HW = $clog2(LOCK_COUNT + 1);

  logic [HW-1:0] hits;
  logic          up_seen;
  logic          dn_seen;
  logic          viol;
  logic          good_cmp;

  assign viol     = (up_q & up_seen) | (dn_q & dn_seen);
  assign good_cmp = up_q & dn_q & ~viol;
  assign locked   = (hits == HW'(LOCK_COUNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits    <= '0;
      up_seen <= 1'b0;
      dn_seen <= 1'b0;
    end else if (!en) begin
      hits    <= '0;
      up_seen <= 1'b0;
      dn_seen <= 1'b0;
    end else begin
      up_seen <= up_q;
      dn_seen <= dn_q;
      if (viol)
        hits <= '0;
      else if (good_cmp && !locked)
        hits <= hits + HW'(1);
    end
  end

  // R6: a pulse that reaches its second cycle drops the lock next cycle
  p_viol_drops_lock_r6: assert property (@(posedge clk) disable iff (!rst_n || !en)
    viol |=> !locked);

  // R5: lock only rises right after a good comparison
  p_lock_rise_r5: assert property (@(posedge clk) disable iff (!rst_n || !en)
    $rose(locked) |-> $past(good_cmp));

endmodule

// File: rtl/refpfd_top.sv
module refpfd_top
  import refpfd_pkg::*;
#(
  parameter int RW         = RATIO_W,
  parameter int SW         = SEL_W,
  parameter int LVL_W      = 8,
  parameter int LOCK_COUNT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [RW-1:0]    ratio_i,
  input  logic [SW-1:0]    post_sel_i,
  input  logic [1:0]       test_sel_i,
  input  logic             main_div_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             ref_div_o,
  output logic             up_o,
  output logic             dn_o,
  output logic             comp_win_o,
  output logic             lock_o,
  output logic             status_o,
  output logic [LVL_W-1:0] level_o
);
  logic ref_evt, ref_pre, ref_post;
  logic up_q, dn_q;
  logic locked;

  refpfd_refdiv #(.RW(RW), .SW(SW)) u_refdiv (
    .clk(clk), .rst_n(rst_n), .en(en_i),
    .ratio(ratio_i), .post_sel(post_sel_i),
    .evt(ref_evt), .pre(ref_pre), .post(ref_post)
  );

  refpfd_detector u_det (
    .clk(clk), .rst_n(rst_n), .en(en_i),
    .ref_evt(ref_evt), .main_i(main_div_i),
    .up_q(up_q), .dn_q(dn_q)
  );

  refpfd_lockmon #(.LOCK_COUNT(LOCK_COUNT)) u_lock (
    .clk(clk), .rst_n(rst_n), .en(en_i),
    .up_q(up_q), .dn_q(dn_q), .locked(locked)
  );

  assign ref_div_o  = ~(en_i & ref_evt);
  assign up_o       = en_i & up_q;
  assign dn_o       = en_i & dn_q;
  assign comp_win_o = en_i & (ref_pre | ref_evt | ref_post);
  assign lock_o     = ~en_i | locked;
  assign level_o    = level_i;

  always_comb begin
    unique case (status_sel_t'(test_sel_i))
      ST_REF:  status_o = ref_div_o;
      ST_MAIN: status_o = main_div_i;
      default: status_o = lock_o;
    endcase
  end

  // R7: a cycle with the block disabled leaves the detector idle
  p_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!up_q && !dn_q && !locked));

endmodule

// File: tb/sim_refpfd_top.sv
module sim_refpfd_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // ratio, post select, expected period
  localparam int VEC [NV][3] = '{
    '{4, 0, 4}, '{5, 1, 10}, '{7, 2, 28}, '{6, 3, 48}, '{2, 0, 4}, '{100, 1, 200}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0;
  logic [11:0] ratio_i = 12'd4;
  logic [1:0] post_sel_i = 2'd0;
  logic [1:0] test_sel_i = 2'd0;
  logic main_div_i = 1'b1;
  logic [7:0] level_i = 8'd0;
  logic ref_div_o, up_o, dn_o, comp_win_o, lock_o, status_o;
  logic [7:0] level_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic up_a [64];
  logic dn_a [64];
  logic lk_a [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  refpfd_top u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .ratio_i(ratio_i),
    .post_sel_i(post_sel_i), .test_sel_i(test_sel_i), .main_div_i(main_div_i),
    .level_i(level_i), .ref_div_o(ref_div_o), .up_o(up_o), .dn_o(dn_o),
    .comp_win_o(comp_win_o), .lock_o(lock_o), .status_o(status_o), .level_o(level_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic start(input int ratio, input int sel);
    @(negedge clk);
    en_i = 1'b0;
    main_div_i = 1'b1;
    repeat (2) @(negedge clk);
    ratio_i = 12'(ratio);
    post_sel_i = 2'(sel);
    @(negedge clk);
    en_i = 1'b1;
  endtask

  function automatic bit is_drop(int j, int off_good, int off_bad, int bad_k);
    for (int k = 0; k < 16; k++) begin
      int off;
      off = (k == bad_k) ? off_bad : off_good;
      if (3 + 4*k + off == j) return 1'b1;
    end
    return 1'b0;
  endfunction

  // ratio 4, no post division: reference events at cycles 3, 7, 11, ...
  task automatic run_seq(input int n, input int off_good, input int off_bad, input int bad_k);
    start(4, 0);
    for (int j = 0; j < n; j++) begin
      main_div_i = is_drop(j, off_good, off_bad, bad_k) ? 1'b0 : 1'b1;
      #1;
      up_a[j] = up_o;
      dn_a[j] = dn_o;
      lk_a[j] = lock_o;
      @(negedge clk);
    end
    main_div_i = 1'b1;
  endtask

  task automatic run_div(input int ratio, input int sel, input int p);
    int first_lo = -1;
    int second_lo = -1;
    bit win_ok = 1'b1;
    start(ratio, sel);
    for (int j = 0; j <= 2*p + 1; j++) begin
      #1;
      if (!ref_div_o) begin
        if (first_lo < 0) first_lo = j;
        else if (second_lo < 0) second_lo = j;
      end
      if ((j == p-2 || j == p-1 || j == p) && !comp_win_o) win_ok = 1'b0;
      if ((j == p-3 || j == p+1) && comp_win_o) win_ok = 1'b0;
      @(negedge clk);
    end
    chk(first_lo == p-1, "R1/R2", $sformatf("first pulse ratio=%0d sel=%0d", ratio, sel), first_lo, p-1);
    chk(second_lo == 2*p-1, "R1/R2", $sformatf("second pulse ratio=%0d sel=%0d", ratio, sel), second_lo, 2*p-1);
    chk(win_ok, "R4", $sformatf("window shape ratio=%0d sel=%0d", ratio, sel), win_ok, 1);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset state with the block enabled
    en_i = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(ref_div_o && !up_o && !dn_o && !comp_win_o, "R1/R3", "reset idle outputs",
        {ref_div_o, up_o, dn_o, comp_win_o}, 4'b1000);
    @(negedge clk);
    rst_n = 1'b1;
    en_i = 1'b0;

    // table of divider settings
    for (int v = 0; v < NV; v++) run_div(VEC[v][0], VEC[v][1], VEC[v][2]);

    // zero phase error: single-cycle overlap, lock after four comparisons
    run_seq(24, 0, 0, -1);
    chk(up_a[4] && dn_a[4], "R3", "zero phase both high", {up_a[4], dn_a[4]}, 3);
    chk(!up_a[5] && !dn_a[5], "R3", "zero phase cleared", {up_a[5], dn_a[5]}, 0);
    chk(!up_a[3], "R3", "up before event", up_a[3], 0);
    chk(!lk_a[16], "R5", "lock before fourth", lk_a[16], 0);
    chk(lk_a[17], "R5", "lock after fourth", lk_a[17], 1);

    // main late by two cycles in the first comparison
    run_seq(24, 0, 2, 0);
    chk(up_a[4] && up_a[6] && !dn_a[5], "R3", "up leads", {up_a[4], up_a[6], dn_a[5]}, 6);
    chk(dn_a[6] && !up_a[7] && !dn_a[7], "R3", "lead clear", {dn_a[6], up_a[7], dn_a[7]}, 4);
    chk(!lk_a[20] && lk_a[21], "R5", "lock after late start", {lk_a[20], lk_a[21]}, 1);

    // main early by two cycles
    run_seq(8, 0, -2, 0);
    chk(dn_a[2] && !up_a[2], "R3", "down leads", {dn_a[2], up_a[2]}, 2);
    chk(dn_a[4] && up_a[4] && !dn_a[5], "R3", "lag clear", {dn_a[4], up_a[4], dn_a[5]}, 6);

    // lock, then a violation in comparison five
    run_seq(30, 0, 2, 5);
    chk(lk_a[25], "R6", "lock held before violation", lk_a[25], 1);
    chk(!lk_a[26], "R6", "lock dropped", lk_a[26], 0);

    // disabled: nothing moves
    @(negedge clk);
    en_i = 1'b0;
    begin
      bit quiet = 1'b1;
      for (int j = 0; j < 20; j++) begin
        main_div_i = (j % 3 == 0) ? 1'b0 : 1'b1;
        #1;
        if (up_o || dn_o || !ref_div_o || comp_win_o || !lock_o) quiet = 1'b0;
        @(negedge clk);
      end
      main_div_i = 1'b1;
      chk(quiet, "R7", "disabled outputs", quiet, 1);
    end

    // status select
    start(4, 0);
    test_sel_i = 2'b01;
    begin
      bit follow = 1'b1;
      for (int j = 0; j < 8; j++) begin
        #1;
        if (status_o !== ((j == 3 || j == 7) ? 1'b0 : 1'b1)) follow = 1'b0;
        @(negedge clk);
      end
      chk(follow, "R8", "status shows reference output", follow, 1);
    end
    test_sel_i = 2'b11;
    main_div_i = 1'b0;
    #1;
    chk(status_o == 1'b0, "R8", "status main low", status_o, 0);
    @(negedge clk);
    main_div_i = 1'b1;
    #1;
    chk(status_o == 1'b1, "R8", "status main high", status_o, 1);
    test_sel_i = 2'b10;
    #1;
    chk(status_o == 1'b0, "R8", "code 10 shows lock while unlocked", status_o, 0);
    test_sel_i = 2'b00;
    @(negedge clk);
    en_i = 1'b0;
    #1;
    chk(status_o == 1'b1, "R8", "code 00 shows lock while disabled", status_o, 1);

    // current setting pass-through
    level_i = 8'hA5;
    #1;
    chk(level_o == 8'hA5, "R9", "level pass A5", level_o, 8'hA5);
    level_i = 8'h3C;
    #1;
    chk(level_o == 8'h3C, "R9", "level pass 3C", level_o, 8'h3C);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule